// File: doc/BRIEF.md
# NAND Status Poller

This block asks a NAND device whether its last operation has finished, and whether that operation passed. When a start pulse is accepted, it writes the read-status command byte once. It then keeps reading the status byte until the device reports that it is ready, or until a fixed number of reads has been made. Each outcome is turned into a two-bit result code, signalled by a one-cycle done pulse. The NAND pin timing is handled outside the block. The block drives three valid/ready channels toward a bus agent: a command-write channel, a read-request channel and a read-data channel.

Back-pressure rules: the block holds a channel's valid signal and payload stable until the agent accepts them with ready. A transfer happens on a clock edge where valid and ready are both high. On the read-data channel the block is the receiver. It raises `rdat_ready_o` only while it waits for the byte of a read it has already requested. Only one channel is active at a time.

The poll limit `POLL_LIMIT` is a parameter with a default of 100000 reads. The most recent status byte stays visible on `status_o` until the next accepted start.

Top module: `nsp_status_poller`

## Requirements
- R1: An accepted start causes exactly one transfer on the command channel, with byte 0x70. `cmd_valid_o` stays high until `cmd_ready_i` is seen.
- R2: Each poll is one read-request transfer followed by one read-data transfer. The command is not sent again between polls.
- R3: A status byte with bit 6 set ends polling. If bit 0 of that byte is 0, the result is 2'b00 (pass). If bit 0 is 1, the result is 2'b01 (operation failed). Bit 0 has no effect while bit 6 is clear.
- R4: If none of the first `POLL_LIMIT` status bytes has bit 6 set, the result is 2'b10 (timeout). No more than `POLL_LIMIT` reads are made per start.
- R5: `done_o` is high for exactly one cycle, in the cycle after the final read-data transfer. `result_o` changes only together with `done_o` and otherwise holds its value.
- R6: `status_o` shows the last status byte received and holds it until the next accepted start. The accepted start clears it to 0x00.
- R7: A start pulse while `busy_o` is high is ignored. The run in progress is not restarted and no extra command is sent.
- R8: After reset, the block is idle: all valids low, `busy_o` 0, `done_o` 0, `result_o` 2'b00, `status_o` 0x00.
- R9: At most one of `cmd_valid_o`, `rdreq_valid_o` and `rdat_ready_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| cmd_valid_o | output | 1 | Command byte valid |
| cmd_byte_o | output | 8 | Command byte (0x70) |
| cmd_ready_i | input | 1 | Bus agent accepts the command byte |
| rdreq_valid_o | output | 1 | Request one data read |
| rdreq_ready_i | input | 1 | Bus agent accepts the read request |
| rdat_valid_i | input | 1 | Status byte valid |
| rdat_byte_i | input | 8 | Status byte from the device |
| rdat_ready_o | output | 1 | Block accepts the status byte |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | 00 pass, 01 failed, 10 timeout |
| status_o | output | 8 | Last status byte received |

## Verification
The bound checker tests the following on every cycle:
- the command byte and that it is held under back-pressure;
- that only one channel is active at a time;
- that the command is not sent again once polling has begun;
- that done is a single-cycle pulse;
- that pass and failure are decoded from a ready byte on the next cycle;
- that the number of reads never exceeds the limit;
- that a command starts only after an accepted start.

Only the bench's scenarios can show the rest:
- the exact read count and final status byte for each byte sequence;
- the timeout result at the boundary of the limit;
- that bit 0 has no effect while the device is busy;
- that a mid-run start is ignored;
- that the status byte is held and then cleared.

// File: rtl/nsp_pkg.sv
package nsp_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] CMD_READ_STATUS = 8'h70;
  localparam int unsigned RDY_BIT = 6;
  localparam int unsigned ERR_BIT = 0;

  typedef enum logic [1:0] {
    RES_PASS    = 2'b00,
    RES_FAIL    = 2'b01,
    RES_TIMEOUT = 2'b10
  } nsp_result_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_REQ  = 2'd2,
    ST_DATA = 2'd3
  } nsp_state_e;
endpackage

// File: rtl/nsp_status_decode.sv
module nsp_status_decode
  import nsp_pkg::*;
#(
  parameter int unsigned W = BYTE_W
) (
  input  logic [W-1:0] byte_i,
  output logic         ready_o,
  output logic         error_o
);
  assign ready_o = byte_i[RDY_BIT];
  assign error_o = byte_i[ERR_BIT];
endmodule

// File: rtl/nsp_poll_counter.sv
module nsp_poll_counter #(
  parameter int unsigned LIMIT = 100000,
  localparam int unsigned CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) cnt_q <= '0;
    else if (inc_i)      cnt_q <= cnt_q + CW'(1);
  end

  // the read now in flight is the final one allowed
  assign last_o = (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/nsp_seq.sv
module nsp_seq
  import nsp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic cmd_ready_i,
  input  logic rdreq_ready_i,
  input  logic rdat_valid_i,
  input  logic dev_ready_i,
  input  logic at_limit_i,
  output logic cmd_valid_o,
  output logic rdreq_valid_o,
  output logic rdat_ready_o,
  output logic busy_o,
  output logic accept_o,
  output logic beat_o,
  output logic finish_o
);
  nsp_state_e state_q, state_d;

  assign accept_o = (state_q == ST_IDLE) && start_i;
  assign beat_o   = (state_q == ST_DATA) && rdat_valid_i;
  assign finish_o = beat_o && (dev_ready_i || at_limit_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i)       state_d = ST_CMD;
      ST_CMD:  if (cmd_ready_i)   state_d = ST_REQ;
      ST_REQ:  if (rdreq_ready_i) state_d = ST_DATA;
      ST_DATA: if (beat_o)        state_d = finish_o ? ST_IDLE : ST_REQ;
      default:                    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign cmd_valid_o   = (state_q == ST_CMD);
  assign rdreq_valid_o = (state_q == ST_REQ);
  assign rdat_ready_o  = (state_q == ST_DATA);
  assign busy_o        = (state_q != ST_IDLE);
endmodule

// File: rtl/nsp_status_poller.sv
module nsp_status_poller
  import nsp_pkg::*;
#(
  parameter int unsigned POLL_LIMIT = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              cmd_valid_o,
  output logic [BYTE_W-1:0] cmd_byte_o,
  input  logic              cmd_ready_i,
  output logic              rdreq_valid_o,
  input  logic              rdreq_ready_i,
  input  logic              rdat_valid_i,
  input  logic [BYTE_W-1:0] rdat_byte_i,
  output logic              rdat_ready_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        result_o,
  output logic [BYTE_W-1:0] status_o
);
  logic dev_ready, dev_error, at_limit;
  logic accept, beat, finish;
  logic done_q;
  logic [1:0] result_q;
  logic [BYTE_W-1:0] status_q;

  nsp_status_decode #(.W(BYTE_W)) u_dec (
    .byte_i (rdat_byte_i),
    .ready_o(dev_ready),
    .error_o(dev_error)
  );

  nsp_poll_counter #(.LIMIT(POLL_LIMIT)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (accept),
    .inc_i (beat),
    .last_o(at_limit)
  );

  nsp_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .cmd_ready_i  (cmd_ready_i),
    .rdreq_ready_i(rdreq_ready_i),
    .rdat_valid_i (rdat_valid_i),
    .dev_ready_i  (dev_ready),
    .at_limit_i   (at_limit),
    .cmd_valid_o  (cmd_valid_o),
    .rdreq_valid_o(rdreq_valid_o),
    .rdat_ready_o (rdat_ready_o),
    .busy_o       (busy_o),
    .accept_o     (accept),
    .beat_o       (beat),
    .finish_o     (finish)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      result_q <= RES_PASS;
      status_q <= '0;
    end else begin
      done_q <= finish;
      if (accept)    status_q <= '0;
      else if (beat) status_q <= rdat_byte_i;
      if (finish) begin
        if (!dev_ready)     result_q <= RES_TIMEOUT;
        else if (dev_error) result_q <= RES_FAIL;
        else                result_q <= RES_PASS;
      end
    end
  end

  assign cmd_byte_o = CMD_READ_STATUS;
  assign done_o     = done_q;
  assign result_o   = result_q;
  assign status_o   = status_q;
endmodule

// File: rtl/nsp_status_poller_chk.sv
module nsp_status_poller_chk #(
  parameter int unsigned POLL_LIMIT = 100000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       cmd_valid_o,
  input logic [7:0] cmd_byte_o,
  input logic       cmd_ready_i,
  input logic       rdreq_valid_o,
  input logic       rdreq_ready_i,
  input logic       rdat_valid_i,
  input logic [7:0] rdat_byte_i,
  input logic       rdat_ready_o,
  input logic       busy_o,
  input logic       done_o,
  input logic [1:0] result_o,
  input logic [7:0] status_o
);
  localparam int unsigned PW = $clog2(POLL_LIMIT + 1) + 1;
  logic [PW-1:0] polls;
  logic rbeat;
  assign rbeat = rdat_valid_i && rdat_ready_o;

  always_ff @(posedge clk) begin
    if (!rst_n)                  polls <= '0;
    else if (start_i && !busy_o) polls <= '0;
    else if (rbeat)              polls <= polls + PW'(1);
  end

  AST_CMD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> cmd_byte_o == 8'h70); // R1
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o); // R1
  AST_NO_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && polls != '0 |-> !cmd_valid_o); // R2
  AST_READY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    rbeat && rdat_byte_i[6] && !rdat_byte_i[0] |=> done_o && result_o == 2'b00); // R3
  AST_READY_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    rbeat && rdat_byte_i[6] && rdat_byte_i[0] |=> done_o && result_o == 2'b01); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    polls <= PW'(POLL_LIMIT)); // R4
  AST_TIMEOUT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && result_o == 2'b10 |-> polls == PW'(POLL_LIMIT)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o)); // R5
  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid_o) |-> $past(start_i && !busy_o)); // R7
  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_valid_o, rdreq_valid_o, rdat_ready_o})); // R9
endmodule

bind nsp_status_poller nsp_status_poller_chk #(.POLL_LIMIT(POLL_LIMIT)) u_chk (.*);

// File: tb/nsp_status_poller_test.sv
module nsp_status_poller_test;
  localparam int unsigned LIM = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic cmd_valid_o, cmd_ready_i = 1'b0;
  logic [7:0] cmd_byte_o;
  logic rdreq_valid_o, rdreq_ready_i = 1'b0;
  logic rdat_valid_i = 1'b0, rdat_ready_o;
  logic [7:0] rdat_byte_i = 8'h00;
  logic busy_o, done_o;
  logic [1:0] result_o;
  logic [7:0] status_o;

  int checks = 0;
  int errors = 0;
  int n_cmd = 0, n_rd = 0, tick = 0;
  bit pending = 0, prev_done = 0, summary_done = 0;
  logic [7:0] resp_q[$];
  logic [1:0] exp_res_q[$];
  logic [7:0] exp_st_q[$];
  int         exp_n_q[$];

  always #10 clk = ~clk;

  nsp_status_poller #(.POLL_LIMIT(LIM)) uut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // bus agent model and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) continue;
      tick++;
      cmd_ready_i   = (tick % 3) != 0;
      rdreq_ready_i = (tick % 2) == 0;
      rdat_valid_i  = pending && ((tick % 4) != 1);
      rdat_byte_i   = (resp_q.size() != 0) ? resp_q[0] : 8'h00;
      if (cmd_valid_o && cmd_ready_i) begin
        n_cmd++;
        check(cmd_byte_o == 8'h70, "R1 cmd byte", cmd_byte_o, 8'h70);
      end
      if (rdreq_valid_o && rdreq_ready_i) pending = 1;
      if (rdat_valid_i && rdat_ready_o) begin
        n_rd++;
        pending = 0;
        if (resp_q.size() != 0) void'(resp_q.pop_front());
      end
      if (prev_done) check(!done_o, "R5 done pulse width", done_o, 0);
      if (done_o && !prev_done) begin
        if (exp_res_q.size() == 0) begin
          check(0, "R5 unexpected done", 1, 0);
        end else begin
          logic [1:0] er; logic [7:0] es; int en;
          er = exp_res_q.pop_front(); es = exp_st_q.pop_front(); en = exp_n_q.pop_front();
          check(result_o == er, "R3/R4 result", result_o, er);
          check(status_o == es, "R6 status byte", status_o, es);
          check(n_rd == en, "R2/R4 read count", n_rd, en);
          check(n_cmd == 1, "R1/R7 command count", n_cmd, 1);
        end
      end
      prev_done = done_o;
    end
  end

  task automatic run_case(input logic [7:0] seq[$], input bit poke_busy);
    logic [1:0] er = 2'b10; logic [7:0] es = 8'h00; int en = LIM;
    for (int i = 0; i < LIM; i++) begin
      logic [7:0] b;
      b = (i < seq.size()) ? seq[i] : 8'h00;
      es = b;
      if (b[6]) begin
        er = b[0] ? 2'b01 : 2'b00;
        en = i + 1;
        break;
      end
    end
    exp_res_q.push_back(er); exp_st_q.push_back(es); exp_n_q.push_back(en);
    @(negedge clk);
    n_cmd = 0; n_rd = 0;
    resp_q = seq;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(status_o == 8'h00, "R6 status cleared on start", status_o, 0);
    check(busy_o == 1'b1, "R7 busy after start", busy_o, 1);
    if (poke_busy) begin
      @(negedge clk);
      start_i = 1'b1; // R7: ignored while busy
      @(negedge clk);
      start_i = 1'b0;
    end
    while (exp_res_q.size() != 0) @(negedge clk);
    repeat (8) @(negedge clk);
    check(status_o == es, "R6 status held", status_o, es);
    check(result_o == er, "R5 result held", result_o, er);
    check(!busy_o && n_cmd == 1, "R7 idle, single command", n_cmd, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy_o && !done_o, "R8 idle after reset", busy_o, 0);
    check(!cmd_valid_o && !rdreq_valid_o && !rdat_ready_o, "R8 valids low", cmd_valid_o, 0);
    check(result_o == 2'b00 && status_o == 8'h00, "R8 result/status", status_o, 0);
    rst_n = 1'b1;
    run_case('{8'h40}, 0);                                   // R3 pass at first read
    run_case('{8'h00, 8'h00, 8'h41}, 0);                     // R3 fail
    run_case('{8'h01, 8'h01, 8'h40}, 0);                     // R3 bit 0 ignored while busy
    run_case('{8'h20, 8'h80, 8'hE0}, 0);                     // R3 other bits
    run_case('{8'h00, 8'h01, 8'h02, 8'h04, 8'h08, 8'h10, 8'h40}, 0); // R4 timeout
    run_case('{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h41}, 0); // R4 ready on last allowed read
    run_case('{8'h80, 8'h80, 8'hC0}, 1);                     // R7 start while busy
    summary_done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!summary_done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule